// File: doc/BRIEF.md
# EPP Hardware Handshake Engine

This block sits between a host register interface and an 8-bit parallel peripheral port. A host access to the port's address register or to one of its data registers becomes a byte cycle run entirely in hardware. The engine drives the direction line and the outgoing byte, then pulls the matching strobe low. It holds the strobe until the peripheral raises its wait line, releases it, and waits for wait to drop again. Throughout, the host access stays pending.

A 16- or 32-bit host access to the first data register is split into two or four byte cycles, least significant byte first. A per-byte watchdog ends any cycle that the peripheral never answers. When it fires, it sets a sticky timeout flag. While that flag is set, every further port access is refused, so a dead peripheral cannot stall the host. A build-time parameter chooses whether a cycle may begin only while wait is low, or begins without looking at wait.

Top module: `epp_cycle_engine`

## Requirements
- R1: Offset 3 runs one cycle on the address strobe `pp_astb_n`. Offsets 4 to 7 run cycles on the data strobe `pp_dstb_n`. Offsets 0 and 2 complete with no strobe and read as zero. The two strobes are never low together.
- R2: Within each byte cycle, `pp_write_n` and `pp_data_oe` are driven at least one clock before the strobe falls, and they stay steady while the strobe is low. The strobe rises only after the synchronised wait line has been seen high. The next byte does not start until wait has been seen low.
- R3: At offset 4, `host_size` selects the burst length: code 1 gives two byte cycles and code 2 gives four. Any other offset or size code gives a single byte cycle.
- R4: Byte k of a burst sends `host_wdata[8k+7:8k]` on writes. On reads, the returned byte k is placed in `host_rdata[8k+7:8k]`, and the unused upper bytes read as zero.
- R5: `host_done` is a single-clock pulse. It comes after the final byte's handshake has finished, or at once for refused and local accesses. Until then the access stays pending.
- R6: If one byte cycle is not finished within TIMEOUT_CYCLES clocks of its start, the engine releases the strobes and sets the timeout flag. It then completes the access with `host_rdata` = 0xFFFFFFFF.
- R7: While the timeout flag is set, accesses to offsets 3 to 7 drive no strobe and complete with `host_rdata` = 0xFFFFFFFF.
- R8: A read of offset 1 returns the timeout flag in bit 0 and zeros elsewhere. A write to offset 1 with bit 0 = 1 clears the flag. A write with bit 0 = 0 leaves it unchanged.
- R9: With WAIT_GATED = 1, no strobe falls while wait is high at the start of a byte. With WAIT_GATED = 0, a cycle starts even with wait held high.
- R10: After reset, both strobes and `pp_write_n` are high, `pp_data_oe` and `host_done` are low, and the timeout flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host access request, held until `host_done` |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset 0..7 |
| host_size | input | 2 | 0 = byte, 1 = 16-bit, 2 = 32-bit |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with `host_done` |
| host_done | output | 1 | Access complete pulse |
| pp_data_o | output | 8 | Byte driven toward the peripheral |
| pp_data_oe | output | 1 | Enables the data-line driver |
| pp_data_i | input | 8 | Byte from the peripheral |
| pp_write_n | output | 1 | Low for a write cycle |
| pp_astb_n | output | 1 | Address strobe, active low |
| pp_dstb_n | output | 1 | Data strobe, active low |
| pp_wait | input | 1 | Peripheral handshake (asynchronous) |

## Verification
The bench checks byte ordering and strobe choice across bursts of width 1, 2 and 4. A design that split bursts MSB-first, or that burst at offsets other than 4, would produce the wrong logged byte sequence or the wrong count of cycles.

A silent peripheral must cause a timeout that returns all-ones. Further port accesses must then be refused with no strobe activity, and the flag must clear only on a write of 1. A design with a flag that clears on any write, or that keeps strobing, would be reported.

Two start-gating cases are exercised. With WAIT_GATED = 1, a wait line held high must keep the strobe inactive. With WAIT_GATED = 0, a second instance must strobe even though wait is high.

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine #(
  parameter int TIMEOUT_CYCLES = 2500,
  parameter bit WAIT_GATED     = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_wr,
  input  logic [2:0]  host_addr,
  input  logic [1:0]  host_size,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_done,
  output logic [7:0]  pp_data_o,
  output logic        pp_data_oe,
  input  logic [7:0]  pp_data_i,
  output logic        pp_write_n,
  output logic        pp_astb_n,
  output logic        pp_dstb_n,
  input  logic        pp_wait
);
  localparam int WDW = $clog2(TIMEOUT_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_SETUP, S_STROBE, S_RELEASE, S_DONE} st_t;

  st_t             st;
  logic            wait_m, wait_s;
  logic            is_wr, is_addr, to_flag;
  logic [1:0]      idx, last_idx;
  logic [31:0]     wbuf, rbuf;
  logic [WDW-1:0]  wd;

  wire active = (st == S_SETUP) || (st == S_STROBE) || (st == S_RELEASE);
  wire busy   = active || (st == S_ARM);
  wire wd_hit = (wd == WDW'(TIMEOUT_CYCLES - 1));

  assign host_rdata = rbuf;
  assign host_done  = (st == S_DONE);
  assign pp_data_oe = active && is_wr;
  assign pp_write_n = !(active && is_wr);
  assign pp_data_o  = wbuf[{idx, 3'b000} +: 8];
  assign pp_astb_n  = !((st == S_STROBE) && is_addr);
  assign pp_dstb_n  = !((st == S_STROBE) && !is_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_m <= 1'b0;
      wait_s <= 1'b0;
    end else begin
      wait_m <= pp_wait;
      wait_s <= wait_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      is_wr    <= 1'b0;
      is_addr  <= 1'b0;
      to_flag  <= 1'b0;
      idx      <= '0;
      last_idx <= '0;
      wbuf     <= '0;
      rbuf     <= '0;
      wd       <= '0;
    end else begin
      case (st)
        S_IDLE: if (host_req) begin
          is_wr    <= host_wr;
          is_addr  <= (host_addr == 3'd3);
          wbuf     <= host_wdata;
          idx      <= '0;
          wd       <= '0;
          last_idx <= (host_addr == 3'd4 && host_size == 2'd1) ? 2'd1 :
                      (host_addr == 3'd4 && host_size == 2'd2) ? 2'd3 : 2'd0;
          if (host_addr < 3'd3) begin
            rbuf <= (host_addr == 3'd1) ? {31'b0, to_flag} : 32'b0;
            if (host_wr && host_addr == 3'd1 && host_wdata[0]) to_flag <= 1'b0;
            st <= S_DONE;
          end else if (to_flag) begin
            rbuf <= '1;
            st   <= S_DONE;
          end else begin
            rbuf <= '0;
            st   <= S_ARM;
          end
        end
        S_ARM, S_SETUP, S_STROBE, S_RELEASE: begin
          if (wd_hit) begin
            to_flag <= 1'b1;
            rbuf    <= '1;
            st      <= S_DONE;
          end else begin
            wd <= wd + 1'b1;
            case (st)
              S_ARM:    if (!WAIT_GATED || !wait_s) st <= S_SETUP;
              S_SETUP:  st <= S_STROBE;
              S_STROBE: if (wait_s) begin
                if (!is_wr) rbuf[{idx, 3'b000} +: 8] <= pp_data_i;
                st <= S_RELEASE;
              end
              default:  if (!wait_s) begin
                if (idx == last_idx) st <= S_DONE;
                else begin
                  idx <= idx + 1'b1;
                  wd  <= '0;
                  st  <= S_ARM;
                end
              end
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!pp_astb_n && !pp_dstb_n));

  a_r2_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pp_astb_n) || $fell(pp_dstb_n)) |-> ($stable(pp_write_n) && $stable(pp_data_oe)));

  a_r2_release_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pp_astb_n) || $rose(pp_dstb_n)) |-> ($past(wait_s) || to_flag));

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);

  a_r7_refused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    to_flag |-> (pp_astb_n && pp_dstb_n));

  a_r9_gated_start: assert property (@(posedge clk) disable iff (!rst_n)
    (WAIT_GATED && ($fell(pp_astb_n) || $fell(pp_dstb_n))) |-> !$past(wait_s, 2));

  a_r6_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (wd < WDW'(TIMEOUT_CYCLES)));
endmodule

// File: tb/epp_cycle_engine_bench.sv
`timescale 1ns/1ps
module epp_cycle_engine_bench;
  localparam int TMO = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req = 0, wr = 0;
  logic [2:0]  addr = 0;
  logic [1:0]  size = 0;
  logic [31:0] wdata = 0, rdata;
  logic        done;
  logic [7:0]  d_o, d_i;
  logic        oe, write_n, astb_n, dstb_n, pwait;

  logic p_on = 1, p_force = 0, p_force_val = 0, p_wait = 0;
  int   p_cnt = 0;
  logic [7:0] p_rdata = 8'hA0;
  assign pwait = p_force ? p_force_val : p_wait;
  assign d_i = p_rdata;

  epp_cycle_engine #(.TIMEOUT_CYCLES(TMO), .WAIT_GATED(1'b1)) u_epp_cycle_engine (
    .clk(clk), .rst_n(rst_n), .host_req(req), .host_wr(wr), .host_addr(addr),
    .host_size(size), .host_wdata(wdata), .host_rdata(rdata), .host_done(done),
    .pp_data_o(d_o), .pp_data_oe(oe), .pp_data_i(d_i), .pp_write_n(write_n),
    .pp_astb_n(astb_n), .pp_dstb_n(dstb_n), .pp_wait(pwait));

  logic        req2 = 0;
  logic [31:0] rdata2;
  logic        done2, oe2, wn2, astb2, dstb2;
  logic [7:0]  d_o2;
  epp_cycle_engine #(.TIMEOUT_CYCLES(TMO), .WAIT_GATED(1'b0)) u_epp_cycle_engine_ng (
    .clk(clk), .rst_n(rst_n), .host_req(req2), .host_wr(1'b0), .host_addr(3'd3),
    .host_size(2'd0), .host_wdata(32'd0), .host_rdata(rdata2), .host_done(done2),
    .pp_data_o(d_o2), .pp_data_oe(oe2), .pp_data_i(8'h00), .pp_write_n(wn2),
    .pp_astb_n(astb2), .pp_dstb_n(dstb2), .pp_wait(1'b1));

  int n_chk = 0, n_fail = 0, cyc = 0;
  int ev_n = 0;
  logic       ev_a [64];
  logic       ev_w [64];
  logic       ev_oe [64];
  logic       ev_setup [64];
  logic [7:0] ev_d [64];
  logic prev_a = 1, prev_d = 1, prev_wn = 1;

  always @(posedge clk) begin
    prev_a  <= astb_n;
    prev_d  <= dstb_n;
    prev_wn <= write_n;
    if ((prev_a && !astb_n) || (prev_d && !dstb_n)) begin
      if (ev_n < 64) begin
        ev_a[ev_n]     <= !astb_n;
        ev_w[ev_n]     <= !write_n;
        ev_oe[ev_n]    <= oe;
        ev_setup[ev_n] <= (prev_wn == write_n);
        ev_d[ev_n]     <= d_o;
      end
      p_rdata <= 8'hA0 + 8'(ev_n);
      ev_n    <= ev_n + 1;
    end
    if (p_on) begin
      if (!astb_n || !dstb_n) begin
        if (!p_wait) begin
          if (p_cnt >= 2) begin p_wait <= 1'b1; p_cnt <= 0; end
          else p_cnt <= p_cnt + 1;
        end
      end else if (p_wait) p_wait <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [2:0] a, input logic [1:0] s,
                        input logic [31:0] d, output logic [31:0] rd, output int cycles);
    @(negedge clk);
    req = 1; wr = w; addr = a; size = s; wdata = d;
    cycles = 0;
    do begin
      @(negedge clk);
      cycles++;
    end while (!done && cycles < 2000);
    rd = rdata;
    req = 0;
    @(negedge clk);
    chk(!done, "R5 done single pulse", 32'(done), 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  // {wr, addr, size, wdata, byte count}
  localparam logic [40:0] VEC [10] = '{
    {1'b1, 3'd3, 2'd0, 32'h0000_005A, 3'd1},
    {1'b0, 3'd3, 2'd0, 32'h0,         3'd1},
    {1'b1, 3'd4, 2'd0, 32'h0000_00C3, 3'd1},
    {1'b1, 3'd4, 2'd1, 32'h0000_B2A1, 3'd2},
    {1'b1, 3'd4, 2'd2, 32'h4433_2211, 3'd4},
    {1'b0, 3'd4, 2'd2, 32'h0,         3'd4},
    {1'b0, 3'd4, 2'd1, 32'h0,         3'd2},
    {1'b0, 3'd6, 2'd2, 32'h0,         3'd1},
    {1'b1, 3'd7, 2'd1, 32'h0000_EE77, 3'd1},
    {1'b0, 3'd5, 2'd0, 32'h0,         3'd1}
  };

  initial begin
    logic [31:0] rd;
    int cy, base;
    repeat (3) @(negedge clk);
    chk(astb_n && dstb_n, "R10 strobes high in reset", {30'd0, astb_n, dstb_n}, 32'd3);
    chk(write_n && !oe && !done, "R10 write_n/oe/done in reset", {29'd0, write_n, oe, done}, 32'd4);
    rst_n = 1;
    repeat (2) @(negedge clk);
    access(1'b0, 3'd1, 2'd0, 32'd0, rd, cy);
    chk(rd == 32'd0, "R10 timeout flag clear after reset", rd, 32'd0);

    foreach (VEC[i]) begin
      logic        vw;
      logic [2:0]  va;
      logic [1:0]  vs;
      logic [31:0] vd, exp_rd;
      int          vn;
      {vw, va, vs, vd} = VEC[i][40:3];
      vn   = int'(VEC[i][2:0]);
      base = ev_n;
      access(vw, va, vs, vd, rd, cy);
      chk(ev_n - base == vn, "R3 byte cycle count", 32'(ev_n - base), 32'(vn));
      exp_rd = 32'd0;
      for (int k = 0; k < vn; k++) begin
        chk(ev_a[base+k] == (va == 3'd3), "R1 strobe select", 32'(ev_a[base+k]), 32'(va == 3'd3));
        chk(ev_w[base+k] == vw && ev_oe[base+k] == vw, "R2 direction at strobe",
            {30'd0, ev_w[base+k], ev_oe[base+k]}, {30'd0, vw, vw});
        chk(ev_setup[base+k], "R2 write line set before strobe", 32'(ev_setup[base+k]), 32'd1);
        if (vw) chk(ev_d[base+k] == vd[8*k +: 8], "R4 write byte order", 32'(ev_d[base+k]), 32'(vd[8*k +: 8]));
        exp_rd[8*k +: 8] = 8'hA0 + 8'(base + k);
      end
      if (!vw) chk(rd == exp_rd, "R4 read assembly", rd, exp_rd);
    end

    base = ev_n;
    access(1'b0, 3'd0, 2'd0, 32'd0, rd, cy);
    chk(ev_n == base && rd == 32'd0, "R1 offset 0 local", rd, 32'd0);
    access(1'b1, 3'd2, 2'd0, 32'hFF, rd, cy);
    chk(ev_n == base, "R1 offset 2 no strobe", 32'(ev_n - base), 32'd0);

    // R6 timeout on silent peripheral
    p_on = 0; p_force = 1; p_force_val = 0;
    access(1'b0, 3'd4, 2'd0, 32'd0, rd, cy);
    chk(rd == 32'hFFFF_FFFF, "R6 timeout read data", rd, 32'hFFFF_FFFF);
    chk(cy >= TMO, "R6 timeout not early", 32'(cy), 32'(TMO));
    chk(astb_n && dstb_n, "R6 strobes released", {30'd0, astb_n, dstb_n}, 32'd3);
    access(1'b0, 3'd1, 2'd0, 32'd0, rd, cy);
    chk(rd == 32'd1, "R8 status shows timeout", rd, 32'd1);
    base = ev_n;
    access(1'b1, 3'd4, 2'd2, 32'h1234_5678, rd, cy);
    chk(ev_n == base && rd == 32'hFFFF_FFFF, "R7 refused while timed out", rd, 32'hFFFF_FFFF);
    access(1'b1, 3'd1, 2'd0, 32'hFFFF_FFFE, rd, cy);
    access(1'b0, 3'd1, 2'd0, 32'd0, rd, cy);
    chk(rd == 32'd1, "R8 write 0 keeps flag", rd, 32'd1);
    access(1'b1, 3'd1, 2'd0, 32'd1, rd, cy);
    access(1'b0, 3'd1, 2'd0, 32'd0, rd, cy);
    chk(rd == 32'd0, "R8 write 1 clears flag", rd, 32'd0);
    p_force = 0; p_on = 1;
    base = ev_n;
    access(1'b1, 3'd3, 2'd0, 32'h99, rd, cy);
    chk(ev_n - base == 1, "R7 cycles resume after clear", 32'(ev_n - base), 32'd1);

    // R9 gated start
    p_on = 0; p_force = 1; p_force_val = 1;
    base = ev_n;
    @(negedge clk);
    req = 1; wr = 0; addr = 3'd3; size = 0;
    repeat (20) @(negedge clk);
    chk(ev_n == base, "R9 no strobe while wait high", 32'(ev_n - base), 32'd0);
    p_force = 0; p_on = 1;
    cy = 0;
    while (!done && cy < 200) begin @(negedge clk); cy++; end
    req = 0;
    chk(ev_n - base == 1, "R9 starts after wait low", 32'(ev_n - base), 32'd1);
    @(negedge clk);

    // R9 ungated instance strobes with wait high
    req2 = 1;
    cy = 0;
    while (astb2 && cy < 12) begin @(negedge clk); cy++; end
    chk(!astb2, "R9 ungated start with wait high", 32'(astb2), 32'd0);
    cy = 0;
    while (!done2 && cy < 200) begin @(negedge clk); cy++; end
    req2 = 0;
    chk(done2 && rdata2 == 32'hFFFF_FFFF, "R6 ungated instance times out", rdata2, 32'hFFFF_FFFF);
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule